// File: doc/BRIEF.md
# Sixteen-bit multi-cycle processor core

This block is a small multi-cycle processor for a 16-bit, word-addressed instruction set. It holds eight general-purpose registers, a program counter and a three-bit one-hot condition register. It runs register and immediate addition, a PC-relative load, a PC-relative address load, a conditional branch and a trap. One trap vector halts the core. It fetches and loads through a synchronous memory port, where the read data for an address presented in one cycle is valid in the next cycle. The core never drives a write on that port.

Every register result leaves the core on a valid/ready write-back stream. The stream carries the destination index, the value and the flags that the write sets. The result is committed to the register file and to the condition register only in the cycle of the handshake. While `wb_valid` is high and `wb_ready` is low, the core holds the item stable and fetches nothing. `wb_valid` does not drop until the item is taken. A consumer that ties `wb_ready` high sees one write every instruction cycle that produces a result.

An instruction takes fetch, decode and execute cycles. A load adds one memory-read cycle. An instruction that writes a register adds the write-back cycle, which lasts until the handshake.

Top module: `cpu16_core`

## Requirements
- R1: While reset is held and right after it, `mem_addr` is 0x3000, `halted` is 0 and `wb_valid` is 0. The condition register resets to Z (0b010), so a branch that tests only Z as the first instruction is taken.
- R2: The PC is incremented by one in decode, before execution, so LD, LEA and branch targets are the address of the instruction plus one plus the offset.
- R3: ADD (opcode 0b0001) with bit 5 clear writes SR1 (bits 8:6) + SR2 (bits 2:0) into DR (bits 11:9).
- R4: ADD with bit 5 set uses bits 4:0 sign-extended to 16 bits as the second operand, covering −16 to +15.
- R5: Addition wraps modulo 2^16 and the carry is discarded, so 0x0035 + 0xFFD0 gives 0x0005 and 0x8000 + 0x8000 gives 0x0000.
- R6: LD (opcode 0b0010) reads the memory word at the incremented PC plus the sign-extended bits 8:0, with negative offsets included, and writes it into DR.
- R7: LEA (opcode 0b1110) writes the incremented PC plus the sign-extended bits 8:0 into DR. It does not access memory.
- R8: Each register write carries one-hot flags on `wb_flags`, and the condition register takes the same value: N = 0b100 when bit 15 is set, Z = 0b010 when the value is zero, P = 0b001 otherwise.
- R9: BR (opcode 0b0000) loads the incremented PC plus the sign-extended bits 8:0 when any select bit in bits 11:9 (n, z, p) matches the condition register. Otherwise it falls through. A select of 0b000 is never taken. A branch writes no register.
- R10: TRAP (opcode 0b1111) with vector 0x25 in bits 7:0 raises `halted`. After that, `mem_addr` stays constant and no write-back is offered. Any other trap vector is a no-op.
- R11: An opcode other than the five above makes no register write and no flag change. Execution continues at the next address.
- R12: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_reg`, `wb_data` and `wb_flags` stay unchanged. The register and flag update happens only on the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address for fetch or load |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_wdata | output | 16 | Write data, always zero |
| mem_we | output | 1 | Write enable, always low |
| wb_valid | output | 1 | A register write is offered |
| wb_ready | input | 1 | Consumer accepts the offered write |
| wb_reg | output | 3 | Destination register index |
| wb_data | output | 16 | Value being written |
| wb_flags | output | 3 | One-hot N/Z/P flags for the value |
| halted | output | 1 | Halt trap executed; core stopped |

## Verification
A wrong condition register does not show at the ports when it goes wrong. It shows at the next branch, as an extra or missing write-back from the instructions placed behind that branch. Those instructions are chosen so that a wrong path always produces a write that differs from the expected one. A wrong PC or a wrong offset sign shows on the very next write-back, as a wrong LEA value or a wrong loaded word. A register that is committed before the handshake shows up only in the later sums that read it. The program therefore chains each result into the next instruction and runs under a stalling consumer as well as a free-flowing one.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int unsigned XLEN    = 16;
  localparam int unsigned NREG    = 8;
  localparam int unsigned RIDX_W  = $clog2(NREG);
  localparam int unsigned IMM_W   = 5;
  localparam int unsigned OFF_W   = 9;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned FLAG_W  = 3;

  localparam logic [OPC_W-1:0] OPC_BR   = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_LD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_LEA  = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_TRAP = 4'b1111;

  localparam logic [FLAG_W-1:0] FLG_N = 3'b100;
  localparam logic [FLAG_W-1:0] FLG_Z = 3'b010;
  localparam logic [FLAG_W-1:0] FLG_P = 3'b001;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src1;
    logic [RIDX_W-1:0] src2;
    logic              imm_sel;
    logic [XLEN-1:0]   imm;
    logic [XLEN-1:0]   off;
    logic [FLAG_W-1:0] nzp_sel;
    logic [VEC_W-1:0]  vec;
  } dec_t;

  function automatic logic [FLAG_W-1:0] flags_of(input logic [XLEN-1:0] v);
    if (v[XLEN-1])     return FLG_N;
    else if (v == '0)  return FLG_Z;
    else               return FLG_P;
  endfunction

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  output dec_t            dec
);
  localparam int unsigned DST_LSB  = 9;
  localparam int unsigned SRC1_LSB = 6;
  localparam int unsigned MODE_BIT = 5;

  always_comb begin
    dec.opc     = ir[XLEN-1 -: OPC_W];
    dec.dst     = ir[DST_LSB +: RIDX_W];
    dec.src1    = ir[SRC1_LSB +: RIDX_W];
    dec.src2    = ir[RIDX_W-1:0];
    dec.imm_sel = ir[MODE_BIT];
    dec.imm     = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    dec.off     = {{(XLEN-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
    dec.nzp_sel = ir[DST_LSB +: FLAG_W];
    dec.vec     = ir[VEC_W-1:0];
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] ra,
  input  logic [RIDX_W-1:0] rb,
  output logic [XLEN-1:0]   rd_a,
  output logic [XLEN-1:0]   rd_b,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] rf_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        rf_q[g] <= '0;
      else if (we && (wa == RIDX_W'(g)))
        rf_q[g] <= wd;
    end
  end

  assign rd_a = rf_q[ra];
  assign rd_b = rf_q[rb];
endmodule

// File: rtl/cpu16_exec.sv
module cpu16_exec
  import cpu16_pkg::*;
(
  input  dec_t              dec,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [XLEN-1:0]   pc,
  input  logic [FLAG_W-1:0] cond,
  output logic [XLEN-1:0]   add_res,
  output logic [XLEN-1:0]   ea,
  output logic              br_take
);
  logic [XLEN-1:0] operand2;

  always_comb begin
    operand2 = dec.imm_sel ? dec.imm : op_b;
    add_res  = op_a + operand2;
    ea       = pc + dec.off;
    br_take  = |(dec.nzp_sel & cond);
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter logic [XLEN-1:0]  RESET_PC = 16'h3000,
  parameter logic [VEC_W-1:0] HALT_VEC = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              mem_we,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [XLEN-1:0]   wb_data,
  output logic [FLAG_W-1:0] wb_flags,
  output logic              halted
);
  state_e            state_q;
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   ir_q;
  logic [XLEN-1:0]   res_q;
  logic [FLAG_W-1:0] cond_q;

  dec_t              dec;
  logic [XLEN-1:0]   rd_a, rd_b, add_res, ea;
  logic              br_take;
  logic              commit;

  cpu16_decode u_dec (
    .ir  (ir_q),
    .dec (dec)
  );

  cpu16_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra    (dec.src1),
    .rb    (dec.src2),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .we    (commit),
    .wa    (dec.dst),
    .wd    (res_q)
  );

  cpu16_exec u_exe (
    .dec     (dec),
    .op_a    (rd_a),
    .op_b    (rd_b),
    .pc      (pc_q),
    .cond    (cond_q),
    .add_res (add_res),
    .ea      (ea),
    .br_take (br_take)
  );

  assign commit = (state_q == ST_WB) && wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      res_q   <= '0;
      cond_q  <= FLG_Z;
    end else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + XLEN'(1);
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          case (dec.opc)
            OPC_ADD: begin
              res_q   <= add_res;
              state_q <= ST_WB;
            end
            OPC_LEA: begin
              res_q   <= ea;
              state_q <= ST_WB;
            end
            OPC_LD:  state_q <= ST_MEM;
            OPC_BR:  if (br_take) pc_q <= ea;
            OPC_TRAP: if (dec.vec == HALT_VEC) state_q <= ST_HALT;
            default: ;
          endcase
        end
        ST_MEM: begin
          res_q   <= mem_rdata;
          state_q <= ST_WB;
        end
        ST_WB: begin
          if (wb_ready) begin
            cond_q  <= flags_of(res_q);
            state_q <= ST_FETCH;
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    mem_addr  = pc_q;
    if (state_q == ST_EXEC && dec.opc == OPC_LD) mem_addr = ea;
    mem_wdata = '0;
    mem_we    = 1'b0;
    wb_valid  = (state_q == ST_WB);
    wb_reg    = dec.dst;
    wb_data   = res_q;
    wb_flags  = flags_of(res_q);
    halted    = (state_q == ST_HALT);
  end
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   mem_addr,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [RIDX_W-1:0] wb_reg,
  input logic [XLEN-1:0]   wb_data,
  input logic [FLAG_W-1:0] wb_flags,
  input logic              halted
);
  assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_reg) && $stable(wb_flags)));

  assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($countones(wb_flags) == 1));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_data == '0) |-> (wb_flags == FLG_Z));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(mem_addr)));

  assert_no_wb_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !wb_valid);
endmodule

bind cpu16_core cpu16_core_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .wb_valid (wb_valid),
  .wb_ready (wb_ready),
  .wb_reg   (wb_reg),
  .wb_data  (wb_data),
  .wb_flags (wb_flags),
  .halted   (halted)
);

// File: tb/cpu16_core_tb_top.sv
`timescale 1ns/1ps
module cpu16_core_tb_top;
  import cpu16_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic mem_we, wb_valid, wb_ready, halted;
  logic [2:0] wb_reg, wb_flags;
  logic [15:0] wb_data;

  always #2.5 clk = ~clk;

  cpu16_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_reg(wb_reg), .wb_data(wb_data), .wb_flags(wb_flags), .halted(halted)
  );

  logic [15:0] mem [0:1023];
  always @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

  typedef struct {
    logic [2:0]  r;
    logic [15:0] d;
    logic [2:0]  f;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails = 0;
  int ready_mode = 0;
  int cyc = 0;
  int wd = 0;
  bit we_seen = 0;
  bit prev_stall = 0;
  logic [21:0] prev_item;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic [2:0] r, input logic [15:0] d,
                          input logic [2:0] f, input string req);
    exp_t e;
    e.r = r; e.d = d; e.f = f; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem['h000] = 16'h0401; // BRz +1, taken on reset flags
    mem['h001] = 16'h1FE1; // skipped
    mem['h002] = 16'hE020; // LEA R0
    mem['h003] = 16'h222C; // LD R1 <- 0x3030
    mem['h004] = 16'h202C; // LD R0 <- 0x3031
    mem['h005] = 16'h1401; // ADD R2,R0,R1
    mem['h006] = 16'h16B0; // ADD R3,R2,#-16
    mem['h007] = 16'h18BB; // ADD R4,R2,#-5
    mem['h008] = 16'h0202; // BRp, not taken
    mem['h009] = 16'h0401; // BRz +1, taken
    mem['h00A] = 16'h1FE1; // skipped
    mem['h00B] = 16'hD000; // unimplemented
    mem['h00C] = 16'h0001; // BR none
    mem['h00D] = 16'h2BE2; // LD R5 <- 0x2FF0
    mem['h00E] = 16'hF021; // trap, no-op
    mem['h00F] = 16'h1D61; // ADD R6,R5,#1
    mem['h010] = 16'h0802; // BRn +2
    mem['h011] = 16'h1FE1;
    mem['h012] = 16'h1FE1;
    mem['h013] = 16'h1F86; // ADD R7,R6,R6
    mem['h014] = 16'hF025; // halt
    mem['h015] = 16'h1FE1;
    mem['h030] = 16'hFFD0;
    mem['h031] = 16'h0035;
    mem['h3F0] = 16'h7FFF;
  endtask

  task automatic push_all();
    push_exp(3'd0, 16'h3023, 3'b001, "R7");
    push_exp(3'd1, 16'hFFD0, 3'b100, "R6");
    push_exp(3'd0, 16'h0035, 3'b001, "R2");
    push_exp(3'd2, 16'h0005, 3'b001, "R5");
    push_exp(3'd3, 16'hFFF5, 3'b100, "R4");
    push_exp(3'd4, 16'h0000, 3'b010, "R3");
    push_exp(3'd5, 16'h7FFF, 3'b001, "R6");
    push_exp(3'd6, 16'h8000, 3'b100, "R4");
    push_exp(3'd7, 16'h0000, 3'b010, "R5");
  endtask

  // monitor: ready for the coming edge decided first, then compare
  always @(negedge clk) begin
    cyc++;
    wb_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    if (mem_we) we_seen = 1'b1;
    if (rst_n) begin
      if (prev_stall)
        check(wb_valid && ({wb_reg, wb_data, wb_flags} == prev_item), "R12",
              "held item", {9'd0, wb_valid, wb_reg, wb_data, wb_flags}, {9'd0, 1'b1, prev_item});
      prev_stall = wb_valid && !wb_ready;
      prev_item  = {wb_reg, wb_data, wb_flags};
      if (wb_valid && wb_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected write", {13'd0, wb_reg, wb_data}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(wb_reg == e.r, e.req, "dest", {29'd0, wb_reg}, {29'd0, e.r});
          check(wb_data == e.d, e.req, "data", {16'd0, wb_data}, {16'd0, e.d});
          check(wb_flags == e.f, "R8", "flags", {29'd0, wb_flags}, {29'd0, e.f});
        end
      end
    end else begin
      prev_stall = 0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected < 20000", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_prog(input int mode);
    logic [15:0] a0;
    ready_mode = mode;
    rst_n = 0;
    load_prog();
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(mem_addr == 16'h3000, "R1", "reset address", {16'd0, mem_addr}, 32'h3000);
    check(!halted, "R1", "halted in reset", {31'd0, halted}, 32'd0);
    check(!wb_valid, "R1", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    push_all();
    rst_n = 1;
    @(negedge clk);
    check(mem_addr == 16'h3000, "R1", "first fetch", {16'd0, mem_addr}, 32'h3000);
    while (!halted) @(negedge clk);
    check(exp_q.size() == 0, "R11", "writes left over", exp_q.size(), 32'd0);
    a0 = mem_addr;
    repeat (20) @(negedge clk);
    check(halted, "R10", "halt held", {31'd0, halted}, 32'd1);
    check(mem_addr == a0, "R10", "address frozen", {16'd0, mem_addr}, {16'd0, a0});
    check(!wb_valid, "R10", "no write after halt", {31'd0, wb_valid}, 32'd0);
  endtask

  initial begin
    wb_ready = 1'b1;
    run_prog(1);
    run_prog(0);
    check(!we_seen, "R6", "no write strobe", {31'd0, we_seen}, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule